// File: doc/BRIEF.md
# Double-Buffered Compare/Capture Timer Channel

This block is one channel of a general-purpose timer. An up-counter advances on each prescaler tick while the channel runs. Two compare slots watch that counter. An equality on slot 0 raises its interrupt and drives the pulse output high. An equality on slot 1 raises the other interrupt, drives the pulse output low, and can return the counter to zero, which gives a programmable period and duty cycle.

Each compare slot has an active value, which the comparator sees, and a shadow value. Software picks the update policy with a control bit. With the bit clear, a write lands in both copies at once. With the bit set, a write reaches only the shadow, and both shadows move into the active slots together when the counter matches slot 1. Software can then change period and duty cycle in the middle of a cycle without producing a glitch.

Software can write a compare slot as one 16-bit word or as two byte writes, low byte first. Two capture registers record the counter value. One capture comes from writing zero to a control bit, and the others come from the edges of an external strobe.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: While the run bit (control bit 0) is 1, the counter (read at address 5) goes up by one on each clock edge that has `tick` high. It holds its value on all other edges, and it wraps from 2^CNT_W-1 to 0.
- R2: When the clear bit (control bit 2) is 1, a tick taken while the counter equals compare slot 1 loads 0 into the counter in place of the incremented value.
- R3: A tick taken while the counter equals slot 0 (or slot 1) sets `irq_cmp0` (or `irq_cmp1`) high for exactly the following clock cycle. Neither interrupt is high at any other time.
- R4: The buffering bit is control bit 1 and resets to 0. While it is 0, a committed write to address 1 (slot 0) or address 2 (slot 1) appears in that slot's active value, read back at the same address, from the next cycle.
- R5: While the buffering bit is 1, a committed write changes only the slot's shadow. Both active values take their shadow contents on the edge of a slot-1 match event, and on no other edge.
- R6: Byte enables select the write width: `bus_be`=11 commits the whole word. `bus_be`=01 only stores the low byte in a staging latch, and the slot is unchanged. `bus_be`=10 commits {wdata[15:8], staged low byte}. Values are truncated to CNT_W bits.
- R7: A write to the control register (address 0, `bus_be[0]`=1) with bit 3 equal to 0 copies the counter into capture register 0 (address 3), but only if the run bit was already 1. With the run bit at 0, the write leaves capture register 0 unchanged.
- R8: With control bit 4 set, a rising edge of `cap_strobe` copies the counter into capture register 0. With control bit 5 set, a falling edge copies the counter into capture register 1 (address 4).
- R9: `ppg_out` resets low. It goes high after a slot-0 match event and low after a slot-1 match event, and the slot-1 event wins when both happen on the same edge.
- R10: After reset, the control register reads 0x0008 (bit 3 always reads 1, bits 15:6 read 0), and the counter, both compare slots and both capture registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Write address |
| bus_be | input | 2 | Write byte enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 16 | Read data, combinational from `bus_raddr` |
| tick | input | 1 | Prescaler tick, one clock wide |
| cap_strobe | input | 1 | External capture strobe, synchronous to `clk` |
| irq_cmp0 | output | 1 | Slot-0 match interrupt pulse |
| irq_cmp1 | output | 1 | Slot-1 match interrupt pulse |
| ppg_out | output | 1 | Pulse output set and cleared by the matches |

## Verification
The bench builds the channel with CNT_W set to 10. This makes the counter wrap after 1024 ticks, so a free-running phase passes through the wrap within a short run. It also means the byte writes have to discard the upper bits of the high byte. Setting both compare slots to the same value brings the simultaneous set and clear of the pulse output within reach. Ticks arriving every third cycle separate counter holds from counter steps.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_CMP = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_DBUF  = 1;
  localparam int unsigned B_CLR   = 2;
  localparam int unsigned B_SWCAP = 3;
  localparam int unsigned B_RISE  = 4;
  localparam int unsigned B_FALL  = 5;

  typedef enum logic [1:0] {
    BE_NONE = 2'b00,
    BE_LO   = 2'b01,
    BE_HI   = 2'b10,
    BE_FULL = 2'b11
  } be_e;

  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic clr_en;
    logic dbuf_en;
    logic run;
  } ctrl_t;

  function automatic logic [BUS_W-1:0] ctrl_image(input ctrl_t c);
    return {10'd0, c.fall_en, c.rise_en, 1'b1, c.clr_en, c.dbuf_en, c.run};
  endfunction

  function automatic ctrl_t ctrl_decode(input logic [BUS_W-1:0] d);
    return '{fall_en: d[B_FALL], rise_en: d[B_RISE], clr_en: d[B_CLR],
             dbuf_en: d[B_DBUF], run: d[B_RUN]};
  endfunction

  function automatic logic [BUS_W-1:0] join_bytes(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic sw_capture_fire(input logic wr, input logic [BUS_W-1:0] d,
                                           input logic run_now);
    return wr & ~d[B_SWCAP] & run_now;
  endfunction
endpackage

// File: rtl/tmr_ctrl_reg.sv
`timescale 1ns/1ps
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [BUS_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic             sw_fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_decode(wdata);
  end

  // capture is judged against the run bit held before this write
  assign sw_fire = sw_capture_fire(ctrl_wr, wdata, ctrl.run);
endmodule

// File: rtl/tmr_cmp_slot.sv
`timescale 1ns/1ps
module tmr_cmp_slot
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  be_e              be,
  input  logic [BUS_W-1:0] wdata,
  input  logic             dbuf_en,
  input  logic             xfer,
  output logic [CNT_W-1:0] active
);
  logic [7:0]       stage_q;
  logic [CNT_W-1:0] shadow_q;
  logic             commit;
  logic [BUS_W-1:0] word;

  assign commit = sel && (be == BE_FULL || be == BE_HI);
  assign word   = (be == BE_FULL) ? wdata : join_bytes(wdata[15:8], stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      shadow_q <= '0;
      active   <= '0;
    end else begin
      if (sel && be == BE_LO) stage_q <= wdata[7:0];
      if (commit) shadow_q <= word[CNT_W-1:0];
      if (commit && !dbuf_en) active <= word[CNT_W-1:0];
      else if (xfer)          active <= shadow_q;
    end
  end
endmodule

// File: rtl/tmr_count_unit.sv
`timescale 1ns/1ps
module tmr_count_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr_en,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             hit0,
  output logic             hit1
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic wrap_now);
    return wrap_now ? '0 : c + CNT_W'(1);
  endfunction

  assign step = run & tick;
  assign hit0 = step && (cnt == cmp0);
  assign hit1 = step && (cnt == cmp1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= next_count(cnt, clr_en && hit1);
  end
endmodule

// File: rtl/tmr_capture_unit.sv
`timescale 1ns/1ps
module tmr_capture_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             sw_fire,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap0,
  output logic [CNT_W-1:0] cap1,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic prev_q;

  assign rise_evt = strobe & ~prev_q;
  assign fall_evt = ~strobe & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap0   <= '0;
      cap1   <= '0;
    end else begin
      prev_q <= strobe;
      if (sw_fire || (rise_evt && rise_en)) cap0 <= cnt;
      if (fall_evt && fall_en)              cap1 <= cnt;
    end
  end
endmodule

// File: rtl/tmr_event_out.sv
`timescale 1ns/1ps
module tmr_event_out (
  input  logic clk,
  input  logic rst_n,
  input  logic hit0,
  input  logic hit1,
  output logic irq0,
  output logic irq1,
  output logic ppg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
      ppg  <= 1'b0;
    end else begin
      irq0 <= hit0;
      irq1 <= hit1;
      if (hit1)      ppg <= 1'b0;
      else if (hit0) ppg <= 1'b1;
    end
  end
endmodule

// File: rtl/dbuf_cmp_timer.sv
`timescale 1ns/1ps
module dbuf_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tick,
  input  logic              cap_strobe,
  output logic              irq_cmp0,
  output logic              irq_cmp1,
  output logic              ppg_out
);
  ctrl_t            ctrl;
  logic             ctrl_wr;
  logic             sw_fire;
  logic [CNT_W-1:0] cmp_act [NUM_CMP];
  logic [CNT_W-1:0] cnt;
  logic             step, hit0, hit1;
  logic             xfer;
  logic [CNT_W-1:0] cap0, cap1;
  logic             rise_evt, fall_evt;

  assign ctrl_wr = bus_we && bus_addr == A_CTRL && bus_be[0];
  assign xfer    = hit1 && ctrl.dbuf_en;

  tmr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .ctrl(ctrl), .sw_fire(sw_fire)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
    tmr_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .sel(bus_we && bus_addr == A_CMP0 + ADDR_W'(g)),
      .be(be_e'(bus_be)), .wdata(bus_wdata),
      .dbuf_en(ctrl.dbuf_en), .xfer(xfer), .active(cmp_act[g])
    );
  end

  tmr_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick), .clr_en(ctrl.clr_en),
    .cmp0(cmp_act[0]), .cmp1(cmp_act[1]), .cnt(cnt), .step(step),
    .hit0(hit0), .hit1(hit1)
  );

  tmr_capture_unit #(.CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .rise_en(ctrl.rise_en),
    .fall_en(ctrl.fall_en), .sw_fire(sw_fire), .cnt(cnt), .cap0(cap0), .cap1(cap1),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  tmr_event_out u_events (
    .clk(clk), .rst_n(rst_n), .hit0(hit0), .hit1(hit1),
    .irq0(irq_cmp0), .irq1(irq_cmp1), .ppg(ppg_out)
  );

  always_comb begin
    case (bus_raddr)
      A_CTRL:           bus_rdata = ctrl_image(ctrl);
      A_CMP0:           bus_rdata = BUS_W'(cmp_act[0]);
      A_CMP0 + 3'd1:    bus_rdata = BUS_W'(cmp_act[1]);
      A_CAP0:           bus_rdata = BUS_W'(cap0);
      A_CAP1:           bus_rdata = BUS_W'(cap1);
      A_COUNT:          bus_rdata = BUS_W'(cnt);
      default:          bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             hit0,
  input logic             hit1,
  input logic [CNT_W-1:0] cnt,
  input logic             clr_en,
  input logic             dbuf_en,
  input logic [CNT_W-1:0] act0,
  input logic [CNT_W-1:0] act1,
  input logic             irq0,
  input logic             irq1,
  input logic             ppg,
  input logic [CNT_W-1:0] cap0,
  input logic             sw_fire,
  input logic             rise_evt,
  input logic             rise_en
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step && !(clr_en && hit1) |=> cnt == $past(cnt) + CNT_W'(1));
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && clr_en && hit1 |=> cnt == '0);
  p_irq0_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit0 |=> irq0);
  p_irq0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit0 |=> !irq0);
  p_irq1_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> irq1);
  p_irq1_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit1 |=> !irq1);
  p_dbuf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_en && !hit1 |=> $stable(act0) && $stable(act1));
  p_swcap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> cap0 == $past(cnt));
  p_rise_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt && rise_en |=> cap0 == $past(cnt));
  p_ppg_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> !ppg);
  p_ppg_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit0 && !hit1 |=> ppg);
  p_ppg_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit0 && !hit1 |=> $stable(ppg));
endmodule

bind dbuf_cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .step(step), .hit0(hit0), .hit1(hit1), .cnt(cnt),
  .clr_en(ctrl.clr_en), .dbuf_en(ctrl.dbuf_en), .act0(cmp_act[0]), .act1(cmp_act[1]),
  .irq0(irq_cmp0), .irq1(irq_cmp1), .ppg(ppg_out), .cap0(cap0), .sw_fire(sw_fire),
  .rise_evt(rise_evt), .rise_en(ctrl.rise_en)
);

// File: tb/test_dbuf_cmp_timer.sv
`timescale 1ns/1ps
module test_dbuf_cmp_timer;
  localparam int CNT_W = 10;
  localparam int MOD   = 1 << CNT_W;
  localparam int WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [15:0] bus_rdata;
  logic        tick = 1'b0;
  logic        cap_strobe = 1'b0;
  logic        irq_cmp0, irq_cmp1, ppg_out;

  int n_checks = 0;
  int n_fail = 0;
  int tick_mode = 0;
  bit peeking = 0;

  // reference model state
  bit m_run, m_dbuf, m_clr, m_rise, m_fall, m_prev, m_irq0, m_irq1, m_ppg;
  int m_cnt, m_cap0, m_cap1;
  int m_act[2];
  int m_buf[2];
  int m_stg[2];

  always #2.5 clk = ~clk;

  dbuf_cmp_timer #(.CNT_W(CNT_W)) i_dbuf_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .tick(tick),
    .cap_strobe(cap_strobe), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1), .ppg_out(ppg_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int model_read(input logic [2:0] a);
    case (a)
      3'd0: return (int'(m_fall) << 5) | (int'(m_rise) << 4) | 8 | (int'(m_clr) << 2)
                    | (int'(m_dbuf) << 1) | int'(m_run);
      3'd1: return m_act[0];
      3'd2: return m_act[1];
      3'd3: return m_cap0;
      3'd4: return m_cap1;
      3'd5: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R10 control image";
      3'd1, 3'd2: return "R4 R5 R6 compare slot";
      3'd3, 3'd4: return "R7 R8 capture";
      3'd5: return "R1 R2 counter";
      default: return "R10 unused address";
    endcase
  endfunction

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    bit step, h0, h1, sw, rise, fall, xfer, commit;
    int n_cnt, word, old_buf;
    if (!rst_n) begin
      {m_run, m_dbuf, m_clr, m_rise, m_fall, m_prev, m_irq0, m_irq1, m_ppg} = '0;
      m_cnt = 0; m_cap0 = 0; m_cap1 = 0;
      for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_buf[i] = 0; m_stg[i] = 0; end
    end else begin
      step = m_run && tick;
      h0 = step && (m_cnt == m_act[0]);
      h1 = step && (m_cnt == m_act[1]);
      n_cnt = m_cnt;
      if (step) n_cnt = (m_clr && h1) ? 0 : (m_cnt + 1) % MOD;
      rise = cap_strobe && !m_prev;
      fall = !cap_strobe && m_prev;
      sw = bus_we && bus_addr == 3'd0 && bus_be[0] && !bus_wdata[3] && m_run;
      if (sw || (rise && m_rise)) m_cap0 = m_cnt;
      if (fall && m_fall) m_cap1 = m_cnt;
      xfer = h1 && m_dbuf;
      for (int i = 0; i < 2; i++) begin
        old_buf = m_buf[i];
        commit = 0;
        word = 0;
        if (bus_we && int'(bus_addr) == i + 1) begin
          if (bus_be == 2'b01) m_stg[i] = int'(bus_wdata[7:0]);
          else if (bus_be == 2'b11) begin commit = 1; word = int'(bus_wdata); end
          else if (bus_be == 2'b10) begin
            commit = 1; word = int'(bus_wdata[15:8]) * 256 + m_stg[i];
          end
        end
        word = word % MOD;
        if (commit) m_buf[i] = word;
        if (commit && !m_dbuf) m_act[i] = word;
        else if (xfer) m_act[i] = old_buf;
      end
      m_irq0 = h0;
      m_irq1 = h1;
      if (h1) m_ppg = 0;
      else if (h0) m_ppg = 1;
      if (bus_we && bus_addr == 3'd0 && bus_be[0]) begin
        m_run = bus_wdata[0]; m_dbuf = bus_wdata[1]; m_clr = bus_wdata[2];
        m_rise = bus_wdata[4]; m_fall = bus_wdata[5];
      end
      m_prev = cap_strobe;
      m_cnt = n_cnt;
    end
  end

  // per-cycle comparison against the model
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      check(addr_tag(bus_raddr), bus_rdata, model_read(bus_raddr));
      check("R3 irq_cmp0", irq_cmp0, m_irq0);
      check("R3 irq_cmp1", irq_cmp1, m_irq1);
      check("R9 ppg_out", ppg_out, m_ppg);
    end
  end

  // read address rotation
  initial forever begin
    @(negedge clk);
    #0.5;
    if (!peeking) bus_raddr = (bus_raddr >= 3'd5) ? 3'd0 : bus_raddr + 3'd1;
  end

  // tick generator
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase++;
      case (tick_mode)
        1: tick = 1'b1;
        2: tick = (phase % 3 == 0);
        default: tick = 1'b0;
      endcase
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic bus_wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 2'b00;
  endtask

  task automatic peek(input logic [2:0] a, input string tag, input logic [15:0] exp);
    peeking = 1;
    bus_raddr = a;
    #1.2;
    check(tag, bus_rdata, exp);
    peeking = 0;
  endtask

  task automatic get(input logic [2:0] a, output logic [15:0] v);
    peeking = 1;
    bus_raddr = a;
    #1.2;
    v = bus_rdata;
    peeking = 0;
  endtask

  task automatic toggle_strobe(input int times);
    for (int k = 0; k < times; k++) begin
      @(negedge clk);
      cap_strobe = ~cap_strobe;
      repeat (4 + k) @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    peek(3'd0, "R10 control after reset", 16'h0008);
    peek(3'd5, "R10 counter after reset", 16'h0000);
    peek(3'd1, "R10 slot 0 after reset", 16'h0000);
    peek(3'd4, "R10 capture 1 after reset", 16'h0000);
    check("R10 ppg_out after reset", ppg_out, 1'b0);

    // R4 direct writes, then run with clear on slot 1 match
    bus_wr(3'd1, 2'b11, 16'd5);
    peek(3'd1, "R4 slot 0 direct write", 16'd5);
    bus_wr(3'd2, 2'b11, 16'd12);
    peek(3'd2, "R4 slot 1 direct write", 16'd12);
    bus_wr(3'd0, 2'b01, 16'h000D);
    tick_mode = 1;
    repeat (40) @(negedge clk);

    // R6 byte writes
    bus_wr(3'd2, 2'b01, 16'h0034);
    peek(3'd2, "R6 low byte alone leaves slot unchanged", 16'd12);
    bus_wr(3'd2, 2'b10, 16'h0100);
    peek(3'd2, "R6 high byte completes word", 16'h0134);
    bus_wr(3'd2, 2'b11, 16'd20);

    // R5 buffered writes
    bus_wr(3'd0, 2'b01, 16'h000F);
    bus_wr(3'd1, 2'b11, 16'd7);
    peek(3'd1, "R5 buffered write not yet active", 16'd5);
    repeat (50) @(negedge clk);
    peek(3'd1, "R5 buffered value active after slot 1 match", 16'd7);
    bus_wr(3'd2, 2'b11, 16'd9);
    repeat (50) @(negedge clk);
    peek(3'd2, "R5 slot 1 buffered value applied", 16'd9);

    // R7 software capture, with and without run
    bus_wr(3'd0, 2'b01, 16'h0007);
    repeat (5) @(negedge clk);
    bus_wr(3'd0, 2'b01, 16'h000E);
    get(3'd3, held);
    bus_wr(3'd0, 2'b01, 16'h0006);
    peek(3'd3, "R7 capture ignored while stopped", held);
    peek(3'd0, "R4 control reads back buffering bit", 16'h000E);

    // R8 external strobe edges, sparse ticks
    bus_wr(3'd0, 2'b01, 16'h003D);
    tick_mode = 2;
    toggle_strobe(8);
    bus_wr(3'd0, 2'b01, 16'h001D);
    toggle_strobe(6);
    bus_wr(3'd0, 2'b01, 16'h002D);
    toggle_strobe(6);

    // R9 equal slots: clear wins; R1 wrap without clear
    bus_wr(3'd1, 2'b11, 16'd3);
    bus_wr(3'd2, 2'b11, 16'd3);
    bus_wr(3'd0, 2'b01, 16'h0009);
    tick_mode = 1;
    repeat (1100) @(negedge clk);
    check("R9 ppg_out low with equal slots", ppg_out, 1'b0);

    // R2 short period with byte-written slots
    bus_wr(3'd1, 2'b01, 16'h0002);
    bus_wr(3'd1, 2'b10, 16'h0000);
    bus_wr(3'd2, 2'b11, 16'd6);
    bus_wr(3'd0, 2'b01, 16'h000D);
    repeat (60) @(negedge clk);
    tick_mode = 0;
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule